// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block is a first-in first-out buffer for 9-bit words. It has a write side and a read side, and each side has its own free-running clock. The two clocks can be the same net, or they can run at unrelated rates. A word can be written and another read in the same cycle. Each side is qualified by two enable pins of opposite sense.

The block reports four status flags:
- empty and full;
- almost-empty, whose threshold is programmable;
- almost-full, whose threshold is programmable.

Both thresholds sit in an offset register in the write clock domain. That register is loaded through the write side's second enable pin, which doubles as a load strobe. An active-low reset clears the pointers, the flags, the output register and the offsets.

In stream terms, `full` is the writer's "not ready". A write attempted while `full` is high is dropped. `empty` is the reader's "not valid". A read attempted while `empty` is high is dropped. Read data is registered and held between reads. `oe` forces the visible read data to zero without disturbing the held word. The depth is a power-of-two parameter from 64 to 8192.

Top module: `dcfifo_progflags`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block shows `empty`=1, `aempty`=1, `full`=0, `afull`=0 and `rdata`=0. Both threshold offsets return to 7.
- R2: A word from `din` is stored on a rising `wclk` edge when `wen1_n`=0, `wen2_ld`=1 and `full`=0. Any other combination of the two write enables stores nothing.
- R3: A read happens on a rising `rclk` edge when `ren1_n`=0, `ren2_n`=0 and `empty`=0. After that edge the oldest stored word appears on `rdata` (when `oe`=1). Words come out in write order.
- R4: A write attempted while `full`=1 is ignored. The word is never stored and the write pointer does not move.
- R5: A read attempted while `empty`=1 is ignored. `rdata` keeps its value and the read pointer does not move.
- R6: `full` rises right after the write edge that stores the DEPTH-th word. After a read, `full` stays high through the next `wclk` edge and clears after the second `wclk` edge.
- R7: After a write to an empty FIFO, `empty` stays high through the next `rclk` edge and clears after the second. `empty` rises right after the read edge that takes the last word. Pointers cross clock domains as Gray code, so a synchronized pointer changes by at most one bit per cycle.
- R8: `afull` is 1 exactly when the write side's fill count is at least DEPTH minus the almost-full offset.
- R9: `aempty` is 1 exactly when the read side's fill count is at most the almost-empty offset.
- R10: A `wclk` cycle with `wen1_n`=0 and `wen2_ld`=0 is a load cycle, and it stores no data word. Successive load cycles write `din` (9 bits, zero-extended) first to the almost-empty offset, then to the almost-full offset, and then alternate.
- R11: When `oe`=0, `rdata` is 0. When `oe` returns to 1, the held word shows again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wen1_n | input | 1 | Write enable, active low |
| wen2_ld | input | 1 | High: write enable; low with `wen1_n` low: offset load |
| din | input | 9 | Write data, or offset value in load cycles |
| ren1_n | input | 1 | Read enable, active low |
| ren2_n | input | 1 | Read enable, active low |
| oe | input | 1 | Output enable for `rdata`, active high |
| rdata | output | 9 | Registered read data, zero when `oe` is low |
| empty | output | 1 | No word visible to the read side |
| full | output | 1 | DEPTH words held as seen by the write side |
| aempty | output | 1 | Read-side fill count at or below the almost-empty offset |
| afull | output | 1 | Write-side fill count at or above DEPTH minus the almost-full offset |

## Verification
The assertions assume the following about the inputs:
- The offset register changes only while the read side is idle. The read side uses the offsets without synchronizing them, so they must be quasi-static.
- Reset is held across edges of both clocks.
- Enables and data settle away from clock edges.

The stimulus keeps within these limits:
- It ties both clocks to one source.
- It drives every input on the falling edge.
- It loads offsets only while the FIFO is empty and no read is requested.
- It holds reset for two full cycles.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;
  localparam int WORD_W = 9;
  localparam int OFF_RST = 7;
  localparam int FN_W = 16;

  typedef logic [WORD_W-1:0] word_t;

  function automatic logic [FN_W-1:0] to_gray(input logic [FN_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [FN_W-1:0] from_gray(input logic [FN_W-1:0] g);
    logic [FN_W-1:0] b;
    b[FN_W-1] = g[FN_W-1];
    for (int i = FN_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int W = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

  // R7: a Gray-coded pointer moves by at most one bit per receiving cycle
  a_r7_gray_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(q ^ $past(q)) <= 1);
endmodule

// File: rtl/dcfifo_mem.sv
module dcfifo_mem #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] cells [ENTRIES];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
module dcfifo_wr_ctrl
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW = 6,
  parameter int PW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen1_n,
  input  logic              wen2_ld,
  input  word_t             din,
  input  logic [PW-1:0]     rgray_s,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [PW-1:0]     wgray,
  output logic [WORD_W-1:0] ae_off,
  output logic [WORD_W-1:0] af_off,
  output logic              full,
  output logic              afull
);
  logic [PW-1:0] wptr, wptr_nx, rbin, cnt;
  logic          wr_req, ld_req, ld_sel;

  assign wr_req  = !wen1_n && wen2_ld;
  assign ld_req  = !wen1_n && !wen2_ld;
  assign we      = wr_req && !full;
  assign wptr_nx = wptr + PW'(1);
  assign waddr   = wptr[AW-1:0];

  assign rbin  = PW'(from_gray(FN_W'(rgray_s)));
  assign cnt   = wptr - rbin;
  assign full  = (cnt == PW'(DEPTH));
  assign afull = (32'(cnt) + 32'(af_off)) >= 32'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (we) begin
      wptr  <= wptr_nx;
      wgray <= PW'(to_gray(FN_W'(wptr_nx)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_off <= WORD_W'(OFF_RST);
      af_off <= WORD_W'(OFF_RST);
      ld_sel <= 1'b0;
    end else if (ld_req) begin
      if (ld_sel) af_off <= din;
      else        ae_off <= din;
      ld_sel <= !ld_sel;
    end
  end

  // R4: a write against a full FIFO leaves the pointer where it was
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full) |=> (wptr == $past(wptr)));
  // R10: load cycles never advance the write pointer
  a_r10_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req |=> $stable(wptr));
  // R8: full always lies within the almost-full region
  a_r8_full_in_afull: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> afull);
  // R6: the write-side count never exceeds the depth
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= 32'(DEPTH));
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
module dcfifo_rd_ctrl
  import dcfifo_pkg::*;
#(
  parameter int AW = 6,
  parameter int PW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren1_n,
  input  logic              ren2_n,
  input  logic              oe,
  input  logic [PW-1:0]     wgray_s,
  input  logic [WORD_W-1:0] ae_off,
  input  word_t             mem_q,
  output logic [AW-1:0]     raddr,
  output logic [PW-1:0]     rgray,
  output word_t             rdata,
  output logic              empty,
  output logic              aempty
);
  logic [PW-1:0] rptr, rptr_nx, wbin, cnt;
  logic          rd_req, do_rd;
  word_t         hold_q;

  assign rd_req  = !ren1_n && !ren2_n;
  assign do_rd   = rd_req && !empty;
  assign rptr_nx = rptr + PW'(1);
  assign raddr   = rptr[AW-1:0];

  assign wbin   = PW'(from_gray(FN_W'(wgray_s)));
  assign cnt    = wbin - rptr;
  assign empty  = (cnt == '0);
  assign aempty = 32'(cnt) <= 32'(ae_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      rgray  <= '0;
      hold_q <= '0;
    end else if (do_rd) begin
      rptr   <= rptr_nx;
      rgray  <= PW'(to_gray(FN_W'(rptr_nx)));
      hold_q <= mem_q;
    end
  end

  assign rdata = oe ? hold_q : '0;

  // R5: a read of an empty FIFO leaves pointer and held word untouched
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty) |=> (rptr == $past(rptr) && hold_q == $past(hold_q)));
  // R3: an accepted read advances the pointer by exactly one
  a_r3_read_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !empty) |=> (rptr == PW'($past(rptr) + 1'b1)));
  // R9: empty always lies within the almost-empty region
  a_r9_empty_in_aempty: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> aempty);
endmodule

// File: rtl/dcfifo_progflags.sv
module dcfifo_progflags
  import dcfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       wclk,
  input  logic       rclk,
  input  logic       rst_n,
  input  logic       wen1_n,
  input  logic       wen2_ld,
  input  logic [8:0] din,
  input  logic       ren1_n,
  input  logic       ren2_n,
  input  logic       oe,
  output logic [8:0] rdata,
  output logic       empty,
  output logic       full,
  output logic       aempty,
  output logic       afull
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic              we;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
  logic [WORD_W-1:0] ae_off, af_off;
  word_t             mem_q;

  dcfifo_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(wclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld), .din(din),
    .rgray_s(rgray_s), .we(we), .waddr(waddr), .wgray(wgray),
    .ae_off(ae_off), .af_off(af_off), .full(full), .afull(afull)
  );

  dcfifo_mem #(.AW(AW), .DW(WORD_W)) u_mem (
    .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
    .raddr(raddr), .rdata(mem_q)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  dcfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  dcfifo_rd_ctrl #(.AW(AW), .PW(PW)) u_rd (
    .clk(rclk), .rst_n(rst_n), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe(oe),
    .wgray_s(wgray_s), .ae_off(ae_off), .mem_q(mem_q), .raddr(raddr),
    .rgray(rgray), .rdata(rdata), .empty(empty), .aempty(aempty)
  );
endmodule

// File: tb/tb_dcfifo_progflags.sv
module tb_dcfifo_progflags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1, oe = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] rdata;
  logic empty, full, aempty, afull;
  int nvec = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  dcfifo_progflags #(.DEPTH(64)) dut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .din(din), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe(oe), .rdata(rdata),
    .empty(empty), .full(full), .aempty(aempty), .afull(afull)
  );

  // op: 0 idle, 1 write, 2 read, 3 write+read; then data, then expected read word
  localparam int NV = 19;
  localparam logic [19:0] VEC [NV] = '{
    {2'd1, 9'h1A5, 9'h000}, {2'd1, 9'h0F3, 9'h000}, {2'd1, 9'h100, 9'h000},
    {2'd0, 9'h000, 9'h000}, {2'd0, 9'h000, 9'h000}, {2'd2, 9'h000, 9'h1A5},
    {2'd1, 9'h0AA, 9'h000}, {2'd2, 9'h000, 9'h0F3}, {2'd2, 9'h000, 9'h100},
    {2'd0, 9'h000, 9'h000}, {2'd2, 9'h000, 9'h0AA}, {2'd1, 9'h155, 9'h000},
    {2'd1, 9'h02B, 9'h000}, {2'd0, 9'h000, 9'h000}, {2'd0, 9'h000, 9'h000},
    {2'd3, 9'h1FF, 9'h155}, {2'd2, 9'h000, 9'h02B}, {2'd0, 9'h000, 9'h000},
    {2'd2, 9'h000, 9'h1FF}
  };

  function automatic logic [8:0] fd(input int i);
    return 9'(i * 5 + 3);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [8:0] d);
    wen1_n = 1'b0; wen2_ld = 1'b1; din = d;
    step();
    wen1_n = 1'b1;
  endtask

  task automatic rd();
    ren1_n = 1'b0; ren2_n = 1'b0;
    step();
    ren1_n = 1'b1; ren2_n = 1'b1;
  endtask

  task automatic ld(input logic [8:0] d);
    wen1_n = 1'b0; wen2_ld = 1'b0; din = d;
    step();
    wen1_n = 1'b1; wen2_ld = 1'b1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [8:0] held;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 empty in reset", empty, 1); chk("R1 full in reset", full, 0);
    rst_n = 1'b1;
    step();
    chk("R1 aempty after reset", aempty, 1); chk("R1 afull after reset", afull, 0);
    chk("R1 rdata after reset", rdata, 0);

    // table walk: R2 writes, R3 reads in order, simultaneous read and write
    for (int i = 0; i < NV; i++) begin
      wen1_n = !VEC[i][18]; wen2_ld = 1'b1; din = VEC[i][17:9];
      ren1_n = !VEC[i][19]; ren2_n = !VEC[i][19];
      step();
      if (VEC[i][19]) chk("R3 table read word", rdata, VEC[i][8:0]);
    end
    wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    chk("R7 empty after last read", empty, 1);

    // R5 read of an empty FIFO is ignored
    held = rdata;
    rd();
    chk("R5 rdata kept on empty read", rdata, held);
    wr(9'h033);
    idle(1);
    chk("R7 empty still high one edge after write", empty, 1);
    idle(1);
    chk("R7 empty low two edges after write", empty, 0);
    rd();
    chk("R5 pointer unmoved by empty read", rdata, 9'h033);

    // R2 and R3 enable polarity
    wen1_n = 1'b1; wen2_ld = 1'b1; din = 9'h0EE; step();
    idle(3);
    chk("R2 no write with wen1_n high", empty, 1);
    wr(9'h044); idle(2);
    ren1_n = 1'b0; ren2_n = 1'b1; step();
    chk("R3 no read with ren2_n high", rdata, 9'h033);
    ren1_n = 1'b1; ren2_n = 1'b0; step();
    chk("R3 no read with ren1_n high", rdata, 9'h033);
    ren2_n = 1'b1;
    rd();
    chk("R3 read with both enables", rdata, 9'h044);

    // R11 output enable
    oe = 1'b0; step();
    chk("R11 rdata zero with oe low", rdata, 0);
    oe = 1'b1; step();
    chk("R11 held word back with oe high", rdata, 9'h044);

    // fill to full: R8 threshold, R6, R4
    for (int n = 1; n <= 64; n++) begin
      wr(fd(n - 1));
      if (n == 56) chk("R8 afull low at 56", afull, 0);
      if (n == 57) chk("R8 afull high at 57", afull, 1);
      if (n == 63) chk("R6 not full at 63", full, 0);
    end
    chk("R6 full at depth", full, 1);
    wr(9'h1EE);
    chk("R4 full held on overflow write", full, 1);
    idle(2);
    rd();
    chk("R3 first word after fill", rdata, fd(0));
    chk("R6 full stale right after read", full, 1);
    idle(1);
    chk("R6 full stale one edge later", full, 1);
    idle(1);
    chk("R6 full cleared after second edge", full, 0);
    for (int k = 2; k <= 64; k++) begin
      rd();
      if (rdata != fd(k - 1)) chk("R3 drain order", rdata, fd(k - 1));
      if (k == 56) chk("R9 aempty low at count 8", aempty, 0);
      if (k == 57) chk("R9 aempty high at count 7", aempty, 1);
    end
    nvec++;
    chk("R7 empty after drain", empty, 1);
    rd();
    chk("R4 overflow word never stored", rdata, fd(63));

    // R10 offset loading: almost-empty 3, then almost-full 10
    ld(9'd3); ld(9'd10);
    idle(2);
    chk("R10 load cycles store no word", empty, 1);
    for (int n = 1; n <= 3; n++) wr(9'(n));
    idle(2);
    chk("R10 R9 aempty high at count 3", aempty, 1);
    wr(9'd4); idle(2);
    chk("R10 R9 aempty low at count 4", aempty, 0);
    for (int n = 5; n <= 53; n++) wr(9'(n));
    chk("R10 R8 afull low at 53", afull, 0);
    wr(9'd54);
    chk("R10 R8 afull high at 54", afull, 1);

    // R1 reset mid-run restores state and offsets
    rst_n = 1'b0; step(); step();
    chk("R1 empty during reset", empty, 1); chk("R1 afull during reset", afull, 0);
    chk("R1 rdata during reset", rdata, 0);
    rst_n = 1'b1; step();
    chk("R1 full after mid reset", full, 0);
    for (int n = 0; n < 4; n++) wr(9'(n));
    idle(2);
    chk("R1 aempty offset back to 7 (count 4)", aempty, 1);
    for (int n = 0; n < 4; n++) wr(9'(n));
    idle(2);
    chk("R1 aempty low at count 8", aempty, 0);

    finish_run();
  end
endmodule